// File: doc/BRIEF.md
# DMA Block-Transfer Channel Sequencer

This block is the control engine of one DMA channel working in block mode. Software arms the channel by pulsing a load strobe together with two start addresses (side A and side B), a block length M, a block count N, a unit size (byte or word), and per-side stepping controls. It also loads a selector that names one side as the block area. After that, each pulse on the request input starts one burst of M unit transfers. The burst runs on the per-transfer completion handshake of a simple bus master port, and no further request is needed until the block is done.

After every completed unit, both addresses move by the unit size, each in its own direction and only if stepping is enabled for that side. On the last unit of a block, the block-area side returns to its armed start value. The other side keeps advancing across block boundaries. The channel then waits for the next request. When the N-th block completes, the channel disables itself. If the interrupt enable was loaded as 1, it also raises a sticky end-of-job interrupt.

Top module: `dmab_block_seq`

## Requirements
- R1: A `cfg_load` pulse sets `chan_en` to 1 on the next cycle, puts `src_addr`/`dst_addr` at the loaded start values, clears `irq`, and leaves `bus_req` at 0. After reset, `chan_en`, `bus_req` and `irq` are 0.
- R2: A `req` pulse while the channel is enabled and waiting raises `bus_req` on the next cycle. `bus_req` stays high until M completions have been seen, with no further `req`.
- R3: Each completion (`bus_done` high while `bus_req` is high) moves an address by 1 when `cfg_word`=0 or by 2 when `cfg_word`=1. The move is downward when that side's decrement bit is 1 and upward when it is 0. The address does not move when that side's step-enable bit is 0.
- R4: On the last completion of a block, the block-area address returns to its start value. The block area is side A when `cfg_blk_b`=0 and side B when it is 1. The other address steps normally and keeps advancing across blocks.
- R5: After a block that is not the last, `bus_req` is 0, `chan_en` stays 1, and the next burst waits for a new `req`.
- R6: After the N-th block, `chan_en` and `bus_req` are 0. A loaded N of 0 means 2^OW blocks.
- R7: A loaded M of 0 means 2^IW transfers per block.
- R8: When the job ends with `cfg_irq_en`=1 at load time, `irq` rises and stays high until `irq_clr` or `cfg_load`. With `cfg_irq_en`=0, `irq` stays 0.
- R9: `req` has no effect while `chan_en` is 0, and `bus_done` has no effect while `bus_req` is 0.
- R10: `bus_word` shows the unit size loaded with the last `cfg_load` (1 = word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Arm pulse: captures all configuration and enables the channel |
| cfg_addr_a | input | AW | Start address, side A |
| cfg_addr_b | input | AW | Start address, side B |
| cfg_blk_len | input | IW | Units per block M (0 = 2^IW) |
| cfg_blk_cnt | input | OW | Number of blocks N (0 = 2^OW) |
| cfg_word | input | 1 | Unit size: 0 byte, 1 word |
| cfg_step_a | input | 1 | Side A stepping enable |
| cfg_dec_a | input | 1 | Side A steps downward |
| cfg_step_b | input | 1 | Side B stepping enable |
| cfg_dec_b | input | 1 | Side B steps downward |
| cfg_blk_b | input | 1 | Block area select: 0 side A, 1 side B |
| cfg_irq_en | input | 1 | End-of-job interrupt enable |
| irq_clr | input | 1 | Clears the interrupt |
| req | input | 1 | Transfer request strobe, one per block |
| bus_done | input | 1 | Completion of one unit on the bus port |
| src_addr | output | AW | Current side A address |
| dst_addr | output | AW | Current side B address |
| bus_req | output | 1 | Bus transfer request (burst in progress) |
| bus_word | output | 1 | Unit size flag for the bus port |
| chan_en | output | 1 | Channel enabled |
| irq | output | 1 | End-of-job interrupt request |

## Verification
The bench builds the block with AW=16, IW=4 and OW=4. With these narrow counters, the zero-means-maximum encodings become short jobs: 16 units per block, and 16 blocks per job. Every wrap of the inner counter and the final expiry of the outer counter are therefore compared unit by unit against an address model. With a 16-bit address, decrementing word runs and block rewinds on either side stay short enough to track in full.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } seq_state_e;

  localparam int unsigned SIDES = 2;

endpackage

// File: rtl/dmab_addr_unit.sv
module dmab_addr_unit #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          adv,
  input  logic          rewind,
  input  logic          step_en,
  input  logic          step_dec,
  input  logic          word,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] shadow_q, shadow_d;
  logic [AW-1:0] step;
  logic          upd_en;

  always_comb begin
    step = word ? AW'(2) : AW'(1);
  end

  always_comb begin
    addr_d   = addr_q;
    shadow_d = shadow_q;
    upd_en   = load | adv;
    if (load) begin
      addr_d   = start;
      shadow_d = start;
    end else if (adv) begin
      if (rewind) begin
        addr_d = shadow_q;
      end else if (step_en) begin
        addr_d = step_dec ? (addr_q - step) : (addr_q + step);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      shadow_q <= '0;
    end else if (upd_en) begin
      addr_q   <= addr_d;
      shadow_q <= shadow_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/dmab_count.sv
module dmab_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         upd_en;

  // A stored 0 counts down through the wrap, so it yields 2^W steps.
  always_comb begin
    last = (cnt_q == W'(1));
  end

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    upd_en = load | dec;
    if (load) begin
      hold_d = init;
      cnt_d  = init;
    end else if (dec) begin
      cnt_d = last ? hold_q : (cnt_q - W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/dmab_seq_ctrl.sv
module dmab_seq_ctrl
  import dmab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic irq_en,
  input  logic irq_clr,
  input  logic req,
  input  logic bus_done,
  input  logic in_last,
  input  logic out_last,
  output logic xfer,
  output logic blk_end,
  output logic bus_req,
  output logic chan_en,
  output logic irq
);

  seq_state_e state_q, state_d;
  logic       irq_q, irq_d;
  logic       job_end;

  always_comb begin
    xfer    = (state_q == ST_BURST) && bus_done;
    blk_end = xfer && in_last;
    job_end = blk_end && out_last;
  end

  always_comb begin
    state_d = state_q;
    if (cfg_load) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT:  if (req) state_d = ST_BURST;
        ST_BURST: begin
          if (job_end)      state_d = ST_OFF;
          else if (blk_end) state_d = ST_WAIT;
        end
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (cfg_load)                irq_d = 1'b0;
    else if (job_end && irq_en)  irq_d = 1'b1;
    else if (irq_clr)            irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign bus_req = (state_q == ST_BURST);
  assign chan_en = (state_q != ST_OFF);
  assign irq     = irq_q;

endmodule

// File: rtl/dmab_block_seq.sv
module dmab_block_seq
  import dmab_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned IW = 8,
  parameter int unsigned OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_addr_a,
  input  logic [AW-1:0] cfg_addr_b,
  input  logic [IW-1:0] cfg_blk_len,
  input  logic [OW-1:0] cfg_blk_cnt,
  input  logic          cfg_word,
  input  logic          cfg_step_a,
  input  logic          cfg_dec_a,
  input  logic          cfg_step_b,
  input  logic          cfg_dec_b,
  input  logic          cfg_blk_b,
  input  logic          cfg_irq_en,
  input  logic          irq_clr,
  input  logic          req,
  input  logic          bus_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          bus_req,
  output logic          bus_word,
  output logic          chan_en,
  output logic          irq
);

  logic             word_q;
  logic [SIDES-1:0] step_q;
  logic [SIDES-1:0] dec_q;
  logic             blk_b_q;
  logic             irq_en_q;

  logic             xfer, blk_end, in_last, out_last;
  logic [AW-1:0]    start_v [SIDES];
  logic [AW-1:0]    addr_v  [SIDES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= 1'b0;
      step_q   <= '0;
      dec_q    <= '0;
      blk_b_q  <= 1'b0;
      irq_en_q <= 1'b0;
    end else if (cfg_load) begin
      word_q   <= cfg_word;
      step_q   <= {cfg_step_b, cfg_step_a};
      dec_q    <= {cfg_dec_b, cfg_dec_a};
      blk_b_q  <= cfg_blk_b;
      irq_en_q <= cfg_irq_en;
    end
  end

  assign start_v[0] = cfg_addr_a;
  assign start_v[1] = cfg_addr_b;

  dmab_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .irq_en   (irq_en_q),
    .irq_clr  (irq_clr),
    .req      (req),
    .bus_done (bus_done),
    .in_last  (in_last),
    .out_last (out_last),
    .xfer     (xfer),
    .blk_end  (blk_end),
    .bus_req  (bus_req),
    .chan_en  (chan_en),
    .irq      (irq)
  );

  dmab_count #(.W(IW)) u_inner (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .init  (cfg_blk_len),
    .dec   (xfer),
    .last  (in_last)
  );

  dmab_count #(.W(OW)) u_outer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .init  (cfg_blk_cnt),
    .dec   (blk_end),
    .last  (out_last)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    logic is_blk;
    assign is_blk = (blk_b_q == (g == 1));
    dmab_addr_unit #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .start    (start_v[g]),
      .adv      (xfer),
      .rewind   (blk_end && is_blk),
      .step_en  (step_q[g]),
      .step_dec (dec_q[g]),
      .word     (word_q),
      .addr     (addr_v[g])
    );
  end

  assign src_addr = addr_v[0];
  assign dst_addr = addr_v[1];
  assign bus_word = word_q;

endmodule

// File: rtl/dmab_block_seq_chk.sv
module dmab_block_seq_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          irq_clr,
  input logic          bus_done,
  input logic          bus_req,
  input logic          chan_en,
  input logic          irq,
  input logic          bus_word,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr
);

  // R2
  busreq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> chan_en);

  // R9
  off_stays_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !cfg_load) |=> !bus_req);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !cfg_load) |=> ($stable(src_addr) && $stable(dst_addr)));

  // R6
  en_drop_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) |-> $past(bus_done));

  // R8
  irq_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!chan_en && $past(bus_done)));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !cfg_load) |=> irq);

  // R10
  word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(bus_word));

endmodule

bind dmab_block_seq dmab_block_seq_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_load (cfg_load),
  .irq_clr  (irq_clr),
  .bus_done (bus_done),
  .bus_req  (bus_req),
  .chan_en  (chan_en),
  .irq      (irq),
  .bus_word (bus_word),
  .src_addr (src_addr),
  .dst_addr (dst_addr)
);

// File: tb/dmab_block_seq_tb_top.sv
module dmab_block_seq_tb_top;

  localparam int unsigned AW = 16;
  localparam int unsigned IW = 4;
  localparam int unsigned OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_addr_a = '0;
  logic [AW-1:0] cfg_addr_b = '0;
  logic [IW-1:0] cfg_blk_len = '0;
  logic [OW-1:0] cfg_blk_cnt = '0;
  logic          cfg_word = 1'b0;
  logic          cfg_step_a = 1'b0;
  logic          cfg_dec_a = 1'b0;
  logic          cfg_step_b = 1'b0;
  logic          cfg_dec_b = 1'b0;
  logic          cfg_blk_b = 1'b0;
  logic          cfg_irq_en = 1'b0;
  logic          irq_clr = 1'b0;
  logic          req = 1'b0;
  logic          bus_done = 1'b0;
  logic [AW-1:0] src_addr, dst_addr;
  logic          bus_req, bus_word, chan_en, irq;

  always #5 clk = ~clk;

  dmab_block_seq #(.AW(AW), .IW(IW), .OW(OW)) dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  logic [2*AW-1:0] exp_q [$];
  logic [AW-1:0] ma, mb, sa0, sb0;
  bit m_word, m_sa, m_da, m_sb, m_db, m_blkb;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: after each accepted completion, compare the next address pair.
  initial begin
    bit pend = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (pend) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 scoreboard empty", 0, 1);
        end else begin
          logic [2*AW-1:0] e;
          e = exp_q.pop_front();
          check({src_addr, dst_addr} == e, "R3/R4 addr pair",
                int'({src_addr, dst_addr}), int'(e));
        end
      end
      pend = bus_done && bus_req;
    end
  end

  initial begin
    #1_500_000;
    check(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input bit en, input bit dn);
    logic [AW-1:0] s;
    s = m_word ? AW'(2) : AW'(1);
    if (!en) return a;
    return dn ? a - s : a + s;
  endfunction

  task automatic arm(input logic [AW-1:0] a, input logic [AW-1:0] b, input int m, input int n,
                     input bit w, input bit sa, input bit da, input bit sb, input bit db,
                     input bit blkb, input bit ie);
    @(negedge clk);
    cfg_addr_a = a; cfg_addr_b = b; cfg_blk_len = IW'(m); cfg_blk_cnt = OW'(n);
    cfg_word = w; cfg_step_a = sa; cfg_dec_a = da; cfg_step_b = sb; cfg_dec_b = db;
    cfg_blk_b = blkb; cfg_irq_en = ie; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    ma = a; mb = b; sa0 = a; sb0 = b;
    m_word = w; m_sa = sa; m_da = da; m_sb = sb; m_db = db; m_blkb = blkb;
    #1;
    check(chan_en == 1'b1, "R1 chan_en after load", chan_en, 1);
    check(src_addr == a && dst_addr == b, "R1 start addresses",
          int'({src_addr, dst_addr}), int'({a, b}));
    check(bus_req == 1'b0 && irq == 1'b0, "R1 bus_req/irq after load",
          int'({bus_req, irq}), 0);
    check(bus_word == w, "R10 bus_word", bus_word, w);
  endtask

  task automatic run_block(input int m, input bit last_blk);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    #1;
    check(bus_req == 1'b1, "R2 bus_req after req", bus_req, 1);
    for (int k = 0; k < m; k++) begin
      if (k == 1) @(negedge clk); // gap cycle without completion
      @(negedge clk);
      bus_done = 1'b1;
      if (k == m - 1 && !m_blkb) ma = sa0; else ma = stepped(ma, m_sa, m_da);
      if (k == m - 1 &&  m_blkb) mb = sb0; else mb = stepped(mb, m_sb, m_db);
      exp_q.push_back({ma, mb});
      if (k < m - 1) begin
        @(negedge clk); bus_done = 1'b0;
        #1;
        check(bus_req == 1'b1, "R2 burst continues without req", bus_req, 1);
      end
    end
    @(negedge clk); bus_done = 1'b0;
    #1;
    check(bus_req == 1'b0, "R5 bus_req low at block end", bus_req, 0);
    if (last_blk)
      check(chan_en == 1'b0, "R6 chan_en cleared after last block", chan_en, 0);
    else
      check(chan_en == 1'b1, "R5 chan_en held between blocks", chan_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(chan_en == 0 && bus_req == 0 && irq == 0, "R1 reset state",
          int'({chan_en, bus_req, irq}), 0);

    // R9: request while disabled is ignored
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(bus_req == 1'b0 && chan_en == 1'b0, "R9 req ignored when off",
          int'({chan_en, bus_req}), 0);

    // Job 1: bytes, both increment, A is block area, M=3 N=2, irq enabled
    arm(16'h1000, 16'h2000, 3, 2, 0, 1, 0, 1, 0, 0, 1);
    @(negedge clk); bus_done = 1'b1;
    @(negedge clk); bus_done = 1'b0;
    #1;
    check(src_addr == 16'h1000 && dst_addr == 16'h2000, "R9 bus_done ignored w/o bus_req",
          int'({src_addr, dst_addr}), int'({16'h1000, 16'h2000}));
    run_block(3, 0);
    check(src_addr == 16'h1000, "R4 block area A rewound", src_addr, 16'h1000);
    check(dst_addr == 16'h2003, "R4 side B keeps advancing", dst_addr, 16'h2003);
    run_block(3, 1);
    check(dst_addr == 16'h2006, "R4 side B final", dst_addr, 16'h2006);
    check(irq == 1'b1, "R8 irq raised at end", irq, 1);
    repeat (4) @(negedge clk);
    #1;
    check(irq == 1'b1, "R8 irq sticky", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    #1;
    check(irq == 1'b0, "R8 irq cleared by irq_clr", irq, 0);

    // Job 2: words, A decrements, B is block area, M=2 N=3, irq disabled
    arm(16'h3000, 16'h4000, 2, 3, 1, 1, 1, 1, 0, 1, 0);
    for (int b = 0; b < 3; b++) run_block(2, b == 2);
    check(src_addr == 16'h3000 - 16'd12, "R3 word decrement total", src_addr, 16'h3000 - 16'd12);
    check(dst_addr == 16'h4000, "R4 block area B rewound", dst_addr, 16'h4000);
    check(irq == 1'b0, "R8 no irq when disabled", irq, 0);

    // Job 3: M=0 means 16 units; A not stepping (block area), B decrements bytes; irq on
    arm(16'h5000, 16'h6000, 0, 1, 0, 0, 0, 1, 1, 0, 1);
    run_block(16, 1);
    check(dst_addr == 16'h6000 - 16'd16, "R7 zero length = 16 units", dst_addr, 16'h6000 - 16'd16);
    check(src_addr == 16'h5000, "R3 stepping disabled", src_addr, 16'h5000);
    check(irq == 1'b1, "R8 irq at end of job 3", irq, 1);

    // Job 4: N=0 means 16 blocks of 1 word; cfg_load also clears irq
    arm(16'h0100, 16'h0200, 1, 0, 1, 1, 0, 1, 0, 1, 0);
    for (int b = 0; b < 16; b++) run_block(1, b == 15);
    check(src_addr == 16'h0100 + 16'd32, "R6 zero count = 16 blocks", src_addr, 16'h0100 + 16'd32);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end

endmodule